// File: doc/BRIEF.md
# Variable-Length SPI Shift Engine

This block is the serial core of an SPI port: one 16-bit data register that holds the character to send and, once the transfer is over, the character received. A character may be anywhere from 1 to 16 bits long. Serial timing comes from outside. A strobe input marks each SCK sample edge, and every strobe that the block accepts moves the shift register one place to the left. The outgoing bit always leaves from bit 15. The incoming bit always enters at bit 0. So a short transmit character has to be written left-justified, and a short received character ends up right-justified, with its last bit in bit 0.

As a master, a write to the idle data register starts a transfer, and the transfer runs until the chosen number of strobes has arrived. As a slave, a write only preloads the shift register. The transfer begins with the first strobe from the external master. In both roles a completion flag rises when the last bit has been taken in, and a read of the data register clears it. A write while a transfer is running is dropped and raises a write-collision flag.

Top module: `spi_shift_engine`

## Requirements
- R1: After a synchronous reset, rd_data, done, busy, wcol and ser_out are all 0.
- R2: As a master (is_master=1), a write while idle sets busy in the next cycle, and ser_out then shows bit 15 of the written value.
- R3: Each accepted sck_sample strobe shifts the register left by one: bit 0 takes ser_in, and ser_out presents the next lower bit of the original character.
- R4: char_len uses this encoding: 0 means 16 bits, and 1 to 15 mean that many bits. After exactly that many accepted strobes, busy falls and done is set in the same cycle. rd_data then holds the received bits in its low char_len bits, with the last bit in bit 0, and the remaining transmit bits shifted up above them.
- R5: A read pulse (rd_en) clears done. If a read and a completing strobe fall in the same cycle, done is set.
- R6: A write while busy is ignored and leaves the shift register untouched. It sets wcol, which a read pulse clears.
- R7: As a master, sck_sample strobes while idle have no effect on rd_data, busy or done.
- R8: As a slave (is_master=0), a write while idle loads rd_data and leaves busy low. The first strobe starts the transfer, and done is set after char_len strobes.
- R9: When a write and a strobe arrive in the same cycle while idle, the write wins and the strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| char_len | input | 4 | Character length, 0 encodes 16 |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 16 | Write value, left-justified |
| rd_en | input | 1 | Data register read pulse (clears done and wcol) |
| rd_data | output | 16 | Data register contents |
| sck_sample | input | 1 | One-cycle pulse per SCK sample edge |
| ser_in | input | 1 | Serial receive bit |
| ser_out | output | 1 | Serial transmit bit (bit 15 of the register) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Character complete |
| wcol | output | 1 | Write collision seen |

## Verification
All results are registered, so each one is due exactly one clock edge after the stimulus that causes it. After a write, busy and the loaded value appear at that next edge. After the last strobe, done, the fall of busy and the final rd_data all appear at the same edge. The bench drives inputs on the falling edge and samples outputs on the following falling edge, which is half a period after the edge that registered them. It also checks ser_out before every strobe, so each transmitted bit is compared in the cycle it is on the line.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned LEN_W  = $clog2(DATA_W);
    localparam int unsigned CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic wcol;
    } xfer_flags_t;

    // Length field to bit count: a zero field selects the full register width
    function automatic logic [CNT_W-1:0] char_bits(input logic [LEN_W-1:0] field);
        return (field == '0) ? CNT_W'(DATA_W) : CNT_W'(field);
    endfunction
endpackage

// File: rtl/spi_bit_counter.sv
module spi_bit_counter #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] len,
    output logic          last
);
    logic [CW-1:0] count;

    // >= keeps the counter from running on if len shrinks mid-transfer
    assign last = ((count + CW'(1)) >= len);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step) begin
            count <= last ? '0 : count + CW'(1);
        end
    end

    assert_count_wraps_R4: assert property (@(posedge clk) disable iff (rst)
        (step && last && !clear) |=> (count == '0));
endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         in_bit,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], in_bit};
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sck_sample,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              busy,
    output logic              done,
    output logic              wcol
);
    role_e       role;
    xfer_flags_t flags;
    logic        start_wr;
    logic        collide;
    logic        shift_en;
    logic        last_bit;
    logic        finish;

    assign role     = role_e'(is_master);
    assign start_wr = wr_en && !flags.busy;
    assign collide  = wr_en && flags.busy;
    // Master only shifts inside a transfer; slave shifts whenever the master clocks it
    assign shift_en = sck_sample && !start_wr && (flags.busy || role == ROLE_SLAVE);
    assign finish   = shift_en && last_bit;

    spi_bit_counter #(.CW(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (start_wr),
        .step  (shift_en),
        .len   (char_bits(char_len)),
        .last  (last_bit)
    );

    spi_shift_reg #(.W(DATA_W)) u_sr (
        .clk      (clk),
        .rst      (rst),
        .load     (start_wr),
        .load_val (wr_data),
        .shift    (shift_en),
        .in_bit   (ser_in),
        .q        (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (start_wr && role == ROLE_MASTER) flags.busy <= 1'b1;
            else if (finish)                     flags.busy <= 1'b0;
            else if (shift_en)                   flags.busy <= 1'b1;

            if (finish)     flags.done <= 1'b1;
            else if (rd_en) flags.done <= 1'b0;

            if (collide)    flags.wcol <= 1'b1;
            else if (rd_en) flags.wcol <= 1'b0;
        end
    end

    assign busy    = flags.busy;
    assign done    = flags.done;
    assign wcol    = flags.wcol;
    assign ser_out = rd_data[DATA_W-1];

    assert_master_start_R2: assert property (@(posedge clk) disable iff (rst)
        (is_master && wr_en && !busy) |=> busy);

    assert_done_from_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(sck_sample));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sck_sample) |=> !done);

    assert_collision_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !sck_sample) |=> (wcol && $stable(rd_data)));

    assert_idle_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (is_master && !busy && !wr_en && sck_sample) |=> ($stable(rd_data) && !busy));

    assert_slave_preload_R8: assert property (@(posedge clk) disable iff (rst)
        (!is_master && wr_en && !busy) |=> (!busy && rd_data == $past(wr_data)));
endmodule

// File: tb/spi_shift_engine_bench.sv
module spi_shift_engine_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        is_master;
    logic [3:0]  char_len;
    logic        wr_en;
    logic [15:0] wr_data;
    logic        rd_en;
    logic [15:0] rd_data;
    logic        sck_sample;
    logic        ser_in;
    logic        ser_out;
    logic        busy;
    logic        done;
    logic        wcol;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    spi_shift_engine u_spi_shift_engine (
        .clk(clk), .rst(rst), .is_master(is_master), .char_len(char_len),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .sck_sample(sck_sample), .ser_in(ser_in), .ser_out(ser_out),
        .busy(busy), .done(done), .wcol(wcol)
    );

    // {master, len field, transmit value, receive pattern}
    typedef struct packed {
        logic        m;
        logic [3:0]  len;
        logic [15:0] tx;
        logic [15:0] rx;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd8,  16'hA500, 16'h003C},
        '{1'b1, 4'd0,  16'h1234, 16'hBEEF},
        '{1'b1, 4'd1,  16'h8000, 16'h0001},
        '{1'b1, 4'd15, 16'hFFFE, 16'h2AAA},
        '{1'b0, 4'd4,  16'hC000, 16'h0005},
        '{1'b0, 4'd0,  16'h0F0F, 16'h7001},
        '{1'b0, 4'd12, 16'h5A50, 16'h0963}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_rx(input logic [3:0] f, input logic [15:0] tx,
                                              input logic [15:0] rx);
        int n = (f == 0) ? 16 : int'(f);
        logic [31:0] mask = (32'h1 << n) - 1;
        logic [31:0] full = ({16'h0, tx} << n) | ({16'h0, rx} & mask);
        return full[15:0];
    endfunction

    task automatic idle_inputs();
        wr_en = 0; rd_en = 0; sck_sample = 0; ser_in = 0; wr_data = '0;
    endtask

    task automatic run_xfer(input vec_t v);
        int n = (v.len == 0) ? 16 : int'(v.len);
        is_master = v.m; char_len = v.len;
        wr_en = 1; wr_data = v.tx;
        @(negedge clk); wr_en = 0;
        if (v.m) check("R2 busy after write", {15'h0, busy}, 16'h1);
        else     check("R8 slave stays idle after write", {15'h0, busy}, 16'h0);
        check("R2 loaded value", rd_data, v.tx);
        for (int i = 0; i < n; i++) begin
            check("R3 serial out bit", {15'h0, ser_out}, {15'h0, v.tx[15-i]});
            sck_sample = 1; ser_in = v.rx[n-1-i];
            @(negedge clk); sck_sample = 0;
        end
        check("R4 busy cleared", {15'h0, busy}, 16'h0);
        check("R4 done set", {15'h0, done}, 16'h1);
        check("R4 received value", rd_data, expect_rx(v.len, v.tx, v.rx));
        rd_en = 1; @(negedge clk); rd_en = 0;
        check("R5 read clears done", {15'h0, done}, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs(); is_master = 1; char_len = 0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 rd_data", rd_data, 16'h0);
        check("R1 flags", {12'h0, ser_out, busy, done, wcol}, 16'h0);

        for (int k = 0; k < NV; k++) run_xfer(VECS[k]);

        // R6: collision mid-transfer, master, 4 bits
        is_master = 1; char_len = 4'd4;
        wr_en = 1; wr_data = 16'hB000; @(negedge clk); wr_en = 0;
        sck_sample = 1; ser_in = 1; @(negedge clk); sck_sample = 0;
        wr_en = 1; wr_data = 16'hFFFF; @(negedge clk); wr_en = 0;
        check("R6 wcol set", {15'h0, wcol}, 16'h1);
        check("R6 write ignored", rd_data, 16'h6001);
        check("R6 still busy", {15'h0, busy}, 16'h1);
        for (int i = 0; i < 3; i++) begin
            sck_sample = 1; ser_in = 0; @(negedge clk); sck_sample = 0;
        end
        check("R6 transfer result", rd_data, 16'h0008);
        rd_en = 1; @(negedge clk); rd_en = 0;
        check("R6 read clears wcol", {15'h0, wcol}, 16'h0);

        // R7: master idle strobes do nothing
        sck_sample = 1; ser_in = 1; @(negedge clk);
        @(negedge clk); sck_sample = 0;
        check("R7 rd_data unchanged", rd_data, 16'h0008);
        check("R7 idle flags", {14'h0, busy, done}, 16'h0);

        // R9: write and strobe together in slave idle
        is_master = 0; char_len = 4'd2;
        wr_en = 1; wr_data = 16'hA5A5; sck_sample = 1; ser_in = 1;
        @(negedge clk); wr_en = 0; sck_sample = 0;
        check("R9 write wins", rd_data, 16'hA5A5);
        check("R9 strobe dropped", {15'h0, busy}, 16'h0);
        sck_sample = 1; ser_in = 0; @(negedge clk); sck_sample = 0;
        check("R8 first strobe starts", {15'h0, busy}, 16'h1);
        sck_sample = 1; ser_in = 1; @(negedge clk); sck_sample = 0;
        check("R8 slave done", {15'h0, done}, 16'h1);
        check("R8 slave data", rd_data, 16'h9695);
        rd_en = 1; @(negedge clk); rd_en = 0;

        // R5: completion beats a same-cycle read
        is_master = 1; char_len = 4'd1;
        wr_en = 1; wr_data = 16'h0000; @(negedge clk); wr_en = 0;
        sck_sample = 1; ser_in = 1; rd_en = 1; @(negedge clk);
        sck_sample = 0; rd_en = 0;
        check("R5 set wins over read", {15'h0, done}, 16'h1);
        rd_en = 1; @(negedge clk); rd_en = 0;
        check("R5 later read clears", {15'h0, done}, 16'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule